// File: doc/BRIEF.md
# Serial-Bus Memory Read Slave

This block is the target side of a two-wire serial bus (I2C-style) placed in front of a small byte-addressed memory array. It watches the clock and data lines, recognises start and stop conditions, and answers only to its own 7-bit device address. A host can write a two-byte word address, and then either stop, which only sets the internal read pointer, or issue a repeated start and read.

Reads can start at the current pointer or at a freshly written word address. They continue byte by byte for as long as the host acknowledges. The pointer runs through the whole array and wraps from the last location back to zero. The data line is only ever pulled low (open-drain), to acknowledge or to send a zero bit. The memory is read through a synchronous port: the block presents an address, and the data comes back one clock later.

Top module: `twi_mem_reader`

## Requirements
- R1: A start condition (data falling while clock high) restarts address reception from any state, even in the middle of a byte. A stop condition (data rising while clock high) releases the data line and returns the block to standby.
- R2: The first byte after a start is received MSB first, and bits 7:1 are compared with `DEV_ADDR`. On a match the block pulls data low during the ninth clock. On a mismatch it leaves the line released for that byte and every later byte until the next start.
- R3: After a matched address byte with bit 0 = 0, two word-address bytes (high byte first) are each acknowledged. The pointer is then loaded with the low `AW` bits of {high, low}, and higher bits are ignored.
- R4: A stop after the second word-address byte keeps the loaded pointer and transfers no data.
- R5: A repeated start after the word address, followed by the device address with bit 0 = 1, is acknowledged. The byte at the loaded address is then sent MSB first.
- R6: A read that is not preceded by a word address returns the byte at the current pointer.
- R7: A host acknowledge after a data byte makes the block send the byte at the next address.
- R8: The pointer wraps from 2^AW-1 to 0 during a sequential read.
- R9: After a host non-acknowledge, the data line stays released for any further clocks, and the pointer does not advance again.
- R10: The data line driven by the block changes only while the clock is low.
- R11: After a stop, bytes clocked without a new start are neither acknowledged nor allowed to change the pointer.
- R12: After reset the data line is released, and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | AW | Read address to the memory array |
| mem_rdata | input | 8 | Memory data, valid one clock after `mem_addr` |

## Verification
A corrupted pointer shows up in the very next data byte, as the value for the wrong location. The tests therefore chain their scenarios, so that each current-address read confirms exactly where the previous operation left the pointer. A state machine stuck in or out of an acknowledge phase shows up within one byte: the ninth-clock sample reads the wrong level, or the data byte comes back as all ones. A data-line change while the clock is high would be taken by the host as a false start or stop. A monitor therefore watches for it on every clock from reset onward.

// File: rtl/twi_mem_reader.sv
module twi_mem_reader #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ADEV, S_WHI, S_AHI, S_WLO, S_ALO, S_WAIT, S_TX, S_RACK
  } st_t;

  st_t          st;
  logic [1:0]   scl_sy, sda_sy;
  logic         scl_d, sda_d;
  logic [3:0]   cnt;
  logic [7:0]   sr, ahi, txsr;
  logic         rw, mack;
  logic [AW-1:0] actr;

  wire scl     = scl_sy[1];
  wire sda     = sda_sy[1];
  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c  = scl & scl_d & ~sda_d & sda;
  wire rise    = scl & ~scl_d;
  wire fall    = ~scl & scl_d;
  wire rx      = (st == S_DEV) || (st == S_WHI) || (st == S_WLO);
  wire byte_in = fall && cnt == 4'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl;
      sda_d  <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sr   <= '0;
      ahi  <= '0;
      txsr <= '0;
      rw   <= 1'b0;
      mack <= 1'b0;
      actr <= '0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else if (start_c) begin
      st  <= S_DEV;
      cnt <= '0;
    end else begin
      if (rx && rise && cnt != 4'd8) begin
        sr  <= {sr[6:0], sda};
        cnt <= cnt + 4'd1;
      end
      case (st)
        S_DEV: if (byte_in) begin
          cnt <= '0;
          rw  <= sr[0];
          st  <= (sr[7:1] == DEV_ADDR) ? S_ADEV : S_WAIT;
        end
        S_ADEV: if (fall) begin
          cnt <= '0;
          if (rw) begin
            txsr <= mem_rdata;
            st   <= S_TX;
          end else begin
            st <= S_WHI;
          end
        end
        S_WHI: if (byte_in) begin
          cnt <= '0;
          ahi <= sr;
          st  <= S_AHI;
        end
        S_AHI: if (fall) st <= S_WLO;
        S_WLO: if (byte_in) begin
          cnt  <= '0;
          actr <= AW'({ahi, sr});
          st   <= S_ALO;
        end
        S_ALO: if (fall) st <= S_WAIT;
        S_TX: if (fall) begin
          if (cnt == 4'd7) begin
            cnt  <= '0;
            actr <= actr + 1'b1;
            st   <= S_RACK;
          end else begin
            txsr <= {txsr[6:0], 1'b1};
            cnt  <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (rise) mack <= ~sda;
          if (fall) begin
            if (mack) begin
              txsr <= mem_rdata;
              st   <= S_TX;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe   = (st == S_ADEV) || (st == S_AHI) || (st == S_ALO) ||
                    ((st == S_TX) && !txsr[7]);
  assign mem_addr = actr;

endmodule

// File: rtl/twi_mem_reader_chk.sv
module twi_mem_reader_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [AW-1:0] mem_addr,
  input logic          idle,
  input logic          txing,
  input logic          wlo,
  input logic          stop_det
);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mem_addr) && $past(txing)) |-> mem_addr == AW'($past(mem_addr) + 1'b1));

  // R3
  addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> ($past(txing) || $past(wlo)));

endmodule

bind twi_mem_reader twi_mem_reader_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .mem_addr (mem_addr),
  .idle     (st == S_IDLE),
  .txing    (st == S_TX),
  .wlo      (st == S_WLO),
  .stop_det (stop_c)
);

// File: tb/twi_mem_reader_tb.sv
`timescale 1ns/1ps
module twi_mem_reader_tb;
  localparam int AW = 8;
  localparam int Q  = 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;
  wire sda = ~(m_low | sda_oe);

  int checks = 0;
  int fails  = 0;
  int r10_viol = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twi_mem_reader #(.DEV_ADDR(DEV), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] f(int a);
    return 8'(a * 37) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= f(int'(mem_addr));

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe != oe_prev) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_scl = 0; qw(); m_low = 0; qw(); m_scl = 1; qw(); m_low = 1; qw(); m_scl = 0; qw();
  endtask

  task automatic bus_stop();
    m_scl = 0; m_low = 1; qw(); m_scl = 1; qw(); m_low = 0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw(); m_scl = 1; qw(); qw(); m_scl = 0; qw();
    end
    m_low = 0; qw(); m_scl = 1; qw(); ack = ~sda; qw(); m_scl = 0; qw();
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      qw(); m_scl = 1; qw(); b[i] = sda; qw(); m_scl = 0; qw();
    end
    m_low = ack; qw(); m_scl = 1; qw(); qw(); m_scl = 0; qw(); m_low = 0;
  endtask

  task automatic set_addr(input logic [15:0] w, string tag);
    bit a;
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk(a, {tag, " R2 dev ack"}, a, 1);
    wr_byte(w[15:8], a);     chk(a, {tag, " R3 hi ack"}, a, 1);
    wr_byte(w[7:0], a);      chk(a, {tag, " R3 lo ack"}, a, 1);
  endtask

  task automatic read_seq(int n, int base, string tag);
    bit a;
    logic [7:0] d;
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk(a, {tag, " read ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, d);
      chk(d == f((base + i) % 256), tag, d, f((base + i) % 256));
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda == 1'b1, "R12 line released", sda, 1);
    read_seq(1, 0, "R12 R6 reset pointer");
  endtask

  task automatic t_set_current();
    set_addr(16'h1234, "R4");
    bus_stop();
    read_seq(1, 8'h34, "R4 R6 R3 set current");
  endtask

  task automatic t_random();
    set_addr(16'h0010, "R5");
    read_seq(1, 8'h10, "R5 random read");
  endtask

  task automatic t_seq();
    set_addr(16'h0020, "R7");
    read_seq(4, 8'h20, "R7 sequential");
  endtask

  task automatic t_wrap();
    set_addr(16'hFFFE, "R8");
    read_seq(3, 8'hFE, "R8 wrap");
  endtask

  task automatic t_nack();
    bit a;
    logic [7:0] d;
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk(a, "R9 read ack", a, 1);
    rd_byte(0, d); chk(d == f(1), "R9 first byte", d, f(1));
    rd_byte(0, d); chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    bus_stop();
    read_seq(1, 2, "R9 pointer not advanced");
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    wr_byte({7'h51, 1'b1}, a); chk(!a, "R2 mismatch nack", a, 0);
    wr_byte(8'h00, a);         chk(!a, "R2 later byte ignored", a, 0);
    bus_stop();
    read_seq(1, 3, "R2 pointer kept");
  endtask

  task automatic t_standby();
    bit a;
    wr_byte({DEV, 1'b0}, a); chk(!a, "R11 no start no ack", a, 0);
    wr_byte(8'h00, a);       chk(!a, "R11 second byte", a, 0);
    bus_stop();
    read_seq(1, 4, "R11 pointer kept");
  endtask

  task automatic t_restart();
    bit a;
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk(a, "R1 dev ack", a, 1);
    wr_byte(8'h00, a);       chk(a, "R1 hi ack", a, 1);
    read_seq(1, 5, "R1 abort keeps pointer");
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_current();
    t_random();
    t_seq();
    t_wrap();
    t_nack();
    t_mismatch();
    t_standby();
    t_restart();
    chk(r10_viol == 0, "R10 line change while clock high", r10_viol, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule